// File: doc/BRIEF.md
# Wavefront Memory-Ordering Issue Gate

This block sits beside one wavefront slot of a vector compute unit. Every cycle it examines the decoded class of the instruction at the head of the wavefront's instruction buffer. It reports whether that instruction may issue this cycle. When the scheduler accepts an issue, the block applies the bookkeeping that follows from it: request counters rise and reservation timers are loaded.

Memory traffic is tracked in four classes: global reads, global writes, local reads and local writes. Each class has an in-pipe count and an outstanding count. A read may not pass an older write in the same memory space, and a write may not pass an older read. Atomics count as both a read and a write. Private accesses share the global counters. Flat accesses also use the global counters, but they occupy the bus and issue slot of the space they resolved to.

Barrier and return instructions wait until all memory traffic has drained. Operand readiness arrives as an input flag.

Top module: `wfg_issue_gate`

## Requirements
- R1: `issue_ready` is 0 whenever `wave_run` is 0 (stopped or returning) or `ibuf_empty` is 1.
- R2: A memory read (`mem_dir`=0) or atomic (`mem_dir`=2) to global space (`mem_sp`=0, private 2 or flat 3) is not ready while the global write in-pipe plus outstanding count is nonzero.
- R3: A global-space write (`mem_dir`=1) or atomic is not ready while the global read in-pipe plus outstanding count is nonzero. It becomes ready once that count returns to zero.
- R4: Local-space accesses (`mem_sp`=1) obey the same two ordering rules using only the local counters. Global counts never block them.
- R5: Private accesses are gated by, and increment, the global counters.
- R6: Barrier (`op_cls`=1) and return (`op_cls`=2) are ready only when all eight counters are zero and the SIMD issue slot is free.
- R7: On issue (`issue_fire` = ready and `issue_accept`), a read increments its space's read in-pipe count and a write increments its write count. An atomic increments both. Counter index order in `cnt_inpipe`/`cnt_outst` is 0 global read, 1 global write, 2 local read, 3 local write, each `CNT_W` bits.
- R8: An issued read holds its bus busy for `RD_BUS_CYC` (4) cycles. A write or atomic holds it for `WR_BUS_CYC` (8) cycles. The memory unit slot is busy for `ISSUE_PERIOD` (4) cycles. `resv_busy` bits: 0 global bus, 1 local bus, 2 SIMD slot, 3 global unit slot, 4 local unit slot.
- R9: A flat access (`mem_sp`=3) counts in the global counters. It uses the local bus and slot when `flat_local`=1, and the global ones otherwise.
- R10: A memory op also needs its bus free, its unit slot free, `operands_ok`=1, and the counting space's read-plus-write in-pipe total below its FIFO depth (8).
- R11: A `disp` bit moves one request of that class from in-pipe to outstanding. A `done` bit removes one from outstanding. Increments and decrements on the same edge all apply.
- R12: An ALU op (`op_cls`=0) needs the SIMD slot free and `operands_ok`. Its issue holds the SIMD slot busy for `ISSUE_PERIOD` cycles.
- R13: `issue_accept` while not ready changes no counter and no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_run | input | 1 | Wavefront is running |
| ibuf_empty | input | 1 | Instruction buffer is empty |
| op_cls | input | 2 | 0 ALU, 1 barrier, 2 return, 3 memory |
| mem_sp | input | 2 | 0 global, 1 local, 2 private, 3 flat |
| mem_dir | input | 2 | 0 read, 1 write, 2 atomic, 3 reserved (never ready) |
| flat_local | input | 1 | Flat access resolved to local space |
| operands_ok | input | 1 | Operand registers ready |
| issue_accept | input | 1 | Scheduler takes the instruction |
| disp | input | 4 | Per-class dispatch pulses |
| done | input | 4 | Per-class completion pulses |
| issue_ready | output | 1 | Head instruction may issue |
| issue_fire | output | 1 | Issue happens this cycle |
| resv_busy | output | 5 | Reservation busy flags |
| cnt_inpipe | output | 4*CNT_W | In-pipe counts |
| cnt_outst | output | 4*CNT_W | Outstanding counts |

## Verification
The assertions check several properties on every cycle. No counter underflows on a dispatch or completion pulse. A loaded reservation reads busy on the next cycle. A ready barrier or return always sees all counters drained. A ready global read or write never sees pending traffic in the opposite direction.

Some behaviours only the bench scenarios can show. These are the exact reservation window lengths, the split of a flat access between global counting and local bus use, the FIFO-depth limit, and the independence of local and global ordering. A behavioural model compared every cycle under random traffic covers the interactions.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
  typedef enum logic [1:0] {CLS_ALU, CLS_BARRIER, CLS_RETURN, CLS_MEM} op_cls_e;
  typedef enum logic [1:0] {SP_GLOBAL, SP_LOCAL, SP_PRIVATE, SP_FLAT} mem_sp_e;
  typedef enum logic [1:0] {DIR_READ, DIR_WRITE, DIR_ATOMIC, DIR_RSVD} mem_dir_e;
  localparam int NCLS  = 4;  // counter classes
  localparam int NRESV = 5;  // reservation timers
  localparam int RV_GBUS  = 0;
  localparam int RV_LBUS  = 1;
  localparam int RV_SIMD  = 2;
  localparam int RV_GSLOT = 3;
  localparam int RV_LSLOT = 4;
endpackage

// File: rtl/wfg_flight_cnt.sv
module wfg_flight_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         disp,
  input  logic         done,
  output logic [W-1:0] inpipe,
  output logic [W-1:0] outst
);
  logic [W-1:0] in_q, in_d, out_q, out_d;
  logic         en;

  always_comb begin
    in_d  = in_q + W'(inc) - W'(disp);
    out_d = out_q + W'(disp) - W'(done);
    en    = inc | disp | done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (en) begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign inpipe = in_q;
  assign outst  = out_q;

  // R11: no underflow on dispatch or completion
  a_r11_no_underflow_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    disp |-> in_q != '0);
  a_r11_no_underflow_out: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_q != '0);
  a_r11_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (disp && !done) |=> out_q == $past(out_q) + W'(1));
  // R7: an increment alone raises the in-pipe count by one
  a_r7_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !disp) |=> in_q == $past(in_q) + W'(1));
endmodule

// File: rtl/wfg_resv_timer.sv
module wfg_resv_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          busy
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    en    = load | (cnt_q != '0);
    cnt_d = load ? load_val : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R8: a loaded reservation is visible on the next cycle
  a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);
  a_r8_no_reload_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/wfg_issue_decode.sv
module wfg_issue_decode
  import wfg_pkg::*;
#(
  parameter int W            = 6,
  parameter int TW           = 4,
  parameter int GM_DEPTH     = 8,
  parameter int LM_DEPTH     = 8,
  parameter int ISSUE_PERIOD = 4,
  parameter int RD_BUS_CYC   = 4,
  parameter int WR_BUS_CYC   = 8
) (
  input  logic                      wave_run,
  input  logic                      ibuf_empty,
  input  op_cls_e                   cls,
  input  mem_sp_e                   sp,
  input  mem_dir_e                  dir,
  input  logic                      flat_local,
  input  logic                      operands_ok,
  input  logic                      issue_accept,
  input  logic [NCLS-1:0][W-1:0]    inpipe,
  input  logic [NCLS-1:0][W-1:0]    outst,
  input  logic [NRESV-1:0]          busy,
  output logic                      ready,
  output logic                      fire,
  output logic [NCLS-1:0]           inc,
  output logic [NRESV-1:0]          load,
  output logic [NRESV-1:0][TW-1:0]  load_val
);
  logic [NCLS-1:0] pend;
  logic            mem_idle, is_mem, ord_local, bus_local, rd_like, wr_like;
  logic            order_ok, fifo_ok, bus_free, slot_free, cls_ok;
  logic [W:0]      g_fill, l_fill;
  int unsigned     rd_idx;
  logic [TW-1:0]   bus_len;

  always_comb begin
    for (int i = 0; i < NCLS; i++) pend[i] = (inpipe[i] != '0) || (outst[i] != '0);
    mem_idle  = (pend == '0);
    is_mem    = (cls == CLS_MEM);
    ord_local = (sp == SP_LOCAL);
    bus_local = (sp == SP_LOCAL) || (sp == SP_FLAT && flat_local);
    rd_like   = (dir == DIR_READ)  || (dir == DIR_ATOMIC);
    wr_like   = (dir == DIR_WRITE) || (dir == DIR_ATOMIC);
    rd_idx    = ord_local ? 2 : 0;
    order_ok  = !(rd_like && pend[rd_idx+1]) && !(wr_like && pend[rd_idx]);
    g_fill    = {1'b0, inpipe[0]} + {1'b0, inpipe[1]};
    l_fill    = {1'b0, inpipe[2]} + {1'b0, inpipe[3]};
    fifo_ok   = ord_local ? (l_fill < (W+1)'(LM_DEPTH)) : (g_fill < (W+1)'(GM_DEPTH));
    bus_free  = bus_local ? !busy[RV_LBUS]  : !busy[RV_GBUS];
    slot_free = bus_local ? !busy[RV_LSLOT] : !busy[RV_GSLOT];
    case (cls)
      CLS_ALU:                 cls_ok = !busy[RV_SIMD] && operands_ok;
      CLS_BARRIER, CLS_RETURN: cls_ok = !busy[RV_SIMD] && mem_idle;
      default:                 cls_ok = (dir != DIR_RSVD) && order_ok && bus_free &&
                                        slot_free && fifo_ok && operands_ok;
    endcase
    ready = wave_run && !ibuf_empty && cls_ok;
    fire  = ready && issue_accept;

    inc  = '0;
    load = '0;
    bus_len = (dir == DIR_READ) ? TW'(RD_BUS_CYC) : TW'(WR_BUS_CYC);
    if (fire && is_mem) begin
      inc[rd_idx]   = rd_like;
      inc[rd_idx+1] = wr_like;
      load[bus_local ? RV_LBUS  : RV_GBUS]  = 1'b1;
      load[bus_local ? RV_LSLOT : RV_GSLOT] = 1'b1;
    end else if (fire) begin
      load[RV_SIMD] = 1'b1;
    end
    load_val[RV_GBUS]  = bus_len;
    load_val[RV_LBUS]  = bus_len;
    load_val[RV_SIMD]  = TW'(ISSUE_PERIOD);
    load_val[RV_GSLOT] = TW'(ISSUE_PERIOD);
    load_val[RV_LSLOT] = TW'(ISSUE_PERIOD);
  end
endmodule

// File: rtl/wfg_issue_gate.sv
module wfg_issue_gate
  import wfg_pkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int GM_DEPTH     = 8,
  parameter int LM_DEPTH     = 8,
  parameter int ISSUE_PERIOD = 4,
  parameter int RD_BUS_CYC   = 4,
  parameter int WR_BUS_CYC   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wave_run,
  input  logic                    ibuf_empty,
  input  logic [1:0]              op_cls,
  input  logic [1:0]              mem_sp,
  input  logic [1:0]              mem_dir,
  input  logic                    flat_local,
  input  logic                    operands_ok,
  input  logic                    issue_accept,
  input  logic [3:0]              disp,
  input  logic [3:0]              done,
  output logic                    issue_ready,
  output logic                    issue_fire,
  output logic [4:0]              resv_busy,
  output logic [4*CNT_W-1:0]      cnt_inpipe,
  output logic [4*CNT_W-1:0]      cnt_outst
);
  localparam int MAXB = (WR_BUS_CYC > RD_BUS_CYC) ? WR_BUS_CYC : RD_BUS_CYC;
  localparam int MAXV = (ISSUE_PERIOD > MAXB) ? ISSUE_PERIOD : MAXB;
  localparam int TW   = $clog2(MAXV + 1);

  logic [NCLS-1:0][CNT_W-1:0] inpipe, outst;
  logic [NCLS-1:0]            inc;
  logic [NRESV-1:0]           busy, load;
  logic [NRESV-1:0][TW-1:0]   load_val;

  wfg_issue_decode #(
    .W(CNT_W), .TW(TW), .GM_DEPTH(GM_DEPTH), .LM_DEPTH(LM_DEPTH),
    .ISSUE_PERIOD(ISSUE_PERIOD), .RD_BUS_CYC(RD_BUS_CYC), .WR_BUS_CYC(WR_BUS_CYC)
  ) u_dec (
    .wave_run     (wave_run),
    .ibuf_empty   (ibuf_empty),
    .cls          (op_cls_e'(op_cls)),
    .sp           (mem_sp_e'(mem_sp)),
    .dir          (mem_dir_e'(mem_dir)),
    .flat_local   (flat_local),
    .operands_ok  (operands_ok),
    .issue_accept (issue_accept),
    .inpipe       (inpipe),
    .outst        (outst),
    .busy         (busy),
    .ready        (issue_ready),
    .fire         (issue_fire),
    .inc          (inc),
    .load         (load),
    .load_val     (load_val)
  );

  for (genvar i = 0; i < NCLS; i++) begin : g_cnt
    wfg_flight_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[i]), .disp(disp[i]), .done(done[i]),
      .inpipe(inpipe[i]), .outst(outst[i])
    );
  end

  for (genvar j = 0; j < NRESV; j++) begin : g_resv
    wfg_resv_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(load[j]), .load_val(load_val[j]), .busy(busy[j])
    );
  end

  assign resv_busy  = busy;
  assign cnt_inpipe = inpipe;
  assign cnt_outst  = outst;

  // R1: no issue while stopped or with nothing buffered
  a_r1_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_run || ibuf_empty) |-> !issue_ready);
  // R6: barrier/return only with all traffic drained
  a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ready && (op_cls == 2'd1 || op_cls == 2'd2)) |-> (inpipe == '0 && outst == '0));
  // R2: global-space read never passes a pending global write
  a_r2_raw_global: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ready && op_cls == 2'd3 && mem_sp != 2'd1 && mem_dir != 2'd1)
      |-> (inpipe[1] == '0 && outst[1] == '0));
  // R3: global-space write never passes a pending global read
  a_r3_war_global: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ready && op_cls == 2'd3 && mem_sp != 2'd1 && mem_dir != 2'd0)
      |-> (inpipe[0] == '0 && outst[0] == '0));
  // R13: no bookkeeping without an issue
  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_fire |-> (inc == '0 && load == '0));
endmodule

// File: tb/wfg_issue_gate_bench.sv
`timescale 1ns/1ps
module wfg_issue_gate_bench;
  localparam int W = 6;
  localparam int GMD = 8, LMD = 8, IP = 4, RB = 4, WB = 8;

  logic clk, rst_n;
  logic wave_run, ibuf_empty, flat_local, operands_ok, issue_accept;
  logic [1:0] op_cls, mem_sp, mem_dir;
  logic [3:0] disp, done;
  logic issue_ready, issue_fire;
  logic [4:0] resv_busy;
  logic [4*W-1:0] cnt_inpipe, cnt_outst;

  int checks = 0, failures = 0;
  bit finished = 0;
  int m_in[4], m_out[4], m_t[5];

  wfg_issue_gate #(.CNT_W(W), .GM_DEPTH(GMD), .LM_DEPTH(LMD), .ISSUE_PERIOD(IP),
                   .RD_BUS_CYC(RB), .WR_BUS_CYC(WB)) u_wfg_issue_gate (
    .clk(clk), .rst_n(rst_n), .wave_run(wave_run), .ibuf_empty(ibuf_empty),
    .op_cls(op_cls), .mem_sp(mem_sp), .mem_dir(mem_dir), .flat_local(flat_local),
    .operands_ok(operands_ok), .issue_accept(issue_accept), .disp(disp), .done(done),
    .issue_ready(issue_ready), .issue_fire(issue_fire), .resv_busy(resv_busy),
    .cnt_inpipe(cnt_inpipe), .cnt_outst(cnt_outst));

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int inp(int i);  return int'(cnt_inpipe[i*W +: W]); endfunction
  function automatic int outp(int i); return int'(cnt_outst[i*W +: W]);  endfunction

  function automatic bit m_ready();
    int b;
    bit rdp, wrp, bl;
    if (!wave_run || ibuf_empty) return 0;
    if (op_cls == 0) return (m_t[2] == 0) && operands_ok;
    if (op_cls == 1 || op_cls == 2) begin
      for (int i = 0; i < 4; i++) if (m_in[i] + m_out[i] > 0) return 0;
      return m_t[2] == 0;
    end
    if (mem_dir == 3) return 0;
    b   = (mem_sp == 1) ? 2 : 0;
    rdp = (m_in[b] + m_out[b]) > 0;
    wrp = (m_in[b+1] + m_out[b+1]) > 0;
    if ((mem_dir == 0 || mem_dir == 2) && wrp) return 0;
    if ((mem_dir == 1 || mem_dir == 2) && rdp) return 0;
    bl = (mem_sp == 1) || (mem_sp == 3 && flat_local);
    if (bl ? (m_t[1] > 0 || m_t[4] > 0) : (m_t[0] > 0 || m_t[3] > 0)) return 0;
    if (m_in[b] + m_in[b+1] >= ((b == 2) ? LMD : GMD)) return 0;
    return operands_ok;
  endfunction

  task automatic model_cmp();
    int exp_busy;
    chk(int'(issue_ready), int'(m_ready()), "model ready R1 R2 R3 R4 R6 R10 R12");
    exp_busy = 0;
    for (int k = 0; k < 5; k++) if (m_t[k] > 0) exp_busy |= (1 << k);
    chk(int'(resv_busy), exp_busy, "model busy R8");
    for (int i = 0; i < 4; i++) begin
      chk(inp(i), m_in[i], "model inpipe R7 R11");
      chk(outp(i), m_out[i], "model outst R11");
    end
  endtask

  task automatic model_commit();
    bit f, bl;
    int b;
    f = m_ready() && issue_accept;
    for (int k = 0; k < 5; k++) if (m_t[k] > 0) m_t[k]--;
    if (f && op_cls == 3) begin
      b  = (mem_sp == 1) ? 2 : 0;
      bl = (mem_sp == 1) || (mem_sp == 3 && flat_local);
      if (mem_dir != 1) m_in[b]++;
      if (mem_dir != 0) m_in[b+1]++;
      m_t[bl ? 1 : 0] = (mem_dir == 0) ? RB : WB;
      m_t[bl ? 4 : 3] = IP;
    end else if (f) begin
      m_t[2] = IP;
    end
    for (int i = 0; i < 4; i++) begin
      m_in[i]  -= int'(disp[i]);
      m_out[i] += int'(disp[i]) - int'(done[i]);
    end
  endtask

  // inputs already driven; compare, commit, advance one clock
  task automatic step(int exp, string tag);
    #1;
    if (exp >= 0) chk(int'(issue_ready), exp, tag);
    model_cmp();
    model_commit();
    @(negedge clk);
    issue_accept = 0; disp = 0; done = 0;
  endtask

  task automatic op(int c, int s, int d, bit fl, bit acc);
    op_cls = 2'(c); mem_sp = 2'(s); mem_dir = 2'(d); flat_local = fl; issue_accept = acc;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin op(0, 0, 0, 0, 0); step(-1, ""); end
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wave_run = 1; ibuf_empty = 0; operands_ok = 1;
    op(0, 0, 0, 0, 0); disp = 0; done = 0;
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
    for (int k = 0; k < 5; k++) m_t[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(int'(resv_busy), 0, "R8 reset busy");
    chk(int'(cnt_inpipe), 0, "R11 reset inpipe");
    chk(int'(cnt_outst), 0, "R11 reset outst");

    op(0, 0, 0, 0, 0); step(1, "R12 alu ready");
    wave_run = 0; step(0, "R1 stopped");
    wave_run = 1; ibuf_empty = 1; step(0, "R1 empty");
    ibuf_empty = 0;
    op(0, 0, 0, 0, 1); step(1, "R12 alu issue");
    chk(int'(resv_busy[2]), 1, "R12 simd slot held");
    op(0, 0, 0, 0, 0); step(0, "R12 slot busy");
    op(1, 0, 0, 0, 0); step(0, "R6 slot busy");
    idle(2);
    op(1, 0, 0, 0, 0); step(1, "R6 barrier ready");

    // global read
    op(3, 0, 0, 0, 1); step(1, "R7 global read");
    chk(inp(0), 1, "R7 read count");
    chk(int'(resv_busy[0]), 1, "R8 global bus");
    idle(8);
    op(3, 0, 1, 0, 0); step(0, "R3 write after read");
    op(2, 0, 0, 0, 0); step(0, "R6 return waits");
    op(3, 0, 0, 0, 0); step(1, "R2 read after read");
    op(3, 1, 1, 0, 1); step(1, "R4 local write free");
    idle(9);
    op(3, 1, 0, 0, 0); step(0, "R4 local read after write");
    op(0, 0, 0, 0, 0); disp = 4'b0001; step(-1, "");
    chk(inp(0), 0, "R11 disp inpipe"); chk(outp(0), 1, "R11 disp outst");
    done = 4'b0001; step(-1, "");
    chk(outp(0), 0, "R11 done");
    op(3, 0, 1, 0, 0); step(1, "R3 write after drain");

    // private atomic
    op(3, 2, 2, 0, 1); step(1, "R5 private atomic");
    chk(inp(0), 1, "R7 atomic read"); chk(inp(1), 1, "R5 atomic write");
    idle(9);
    op(3, 0, 0, 0, 0); step(0, "R2 read after atomic");
    op(3, 2, 0, 0, 0); step(0, "R5 private read blocked");
    op(0, 0, 0, 0, 0); disp = 4'b1011; step(-1, "");
    done = 4'b1011; step(-1, "");
    chk(int'(cnt_inpipe), 0, "R11 drained in"); chk(int'(cnt_outst), 0, "R11 drained out");

    // flat write resolved to local
    op(3, 3, 1, 1, 1); step(1, "R9 flat write");
    chk(inp(1), 1, "R9 global count");
    chk(int'(resv_busy[1]), 1, "R9 local bus");
    chk(int'(resv_busy[0]), 0, "R9 global bus idle");
    chk(int'(resv_busy[4]), 1, "R9 local slot");
    for (int n = 1; n <= 7; n++) begin
      idle(1); chk(int'(resv_busy[1]), 1, "R8 write window");
    end
    idle(1); chk(int'(resv_busy[1]), 0, "R8 window end");
    disp = 4'b0010; step(-1, ""); done = 4'b0010; step(-1, "");

    // fifo depth
    for (int n = 0; n < GMD; n++) begin
      op(3, 0, 0, 0, 1); step(1, "R10 fill");
      idle(4);
    end
    op(3, 0, 0, 0, 0); step(0, "R10 fifo full");
    operands_ok = 0; op(3, 1, 0, 0, 0); step(0, "R10 operands");
    operands_ok = 1; step(1, "R10 operands ok");
    op(0, 0, 0, 0, 0); disp = 4'b0001; step(-1, "");
    op(3, 0, 0, 0, 0); step(1, "R10 room again");
    op(3, 0, 0, 0, 1); disp = 4'b0001; step(1, "R11 same edge");
    chk(inp(0), 7, "R11 inc and disp"); chk(outp(0), 2, "R11 outst");
    for (int n = 0; n < 7; n++) begin op(0, 0, 0, 0, 0); disp = 4'b0001; step(-1, ""); end
    for (int n = 0; n < 9; n++) begin done = 4'b0001; step(-1, ""); end
    chk(int'(cnt_outst), 0, "R11 final drain");
    idle(4);

    // accept while not ready
    wave_run = 0; op(3, 0, 0, 0, 1); step(0, "R13 accept ignored");
    chk(int'(cnt_inpipe), 0, "R13 counts"); chk(int'(resv_busy), 0, "R13 busy");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      wave_run    = ($urandom_range(0, 9) != 0);
      ibuf_empty  = ($urandom_range(0, 9) == 0);
      operands_ok = ($urandom_range(0, 7) != 0);
      op($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int i = 0; i < 4; i++) begin
        disp[i] = (m_in[i] > 0) && ($urandom_range(0, 1) == 1);
        done[i] = (m_out[i] > 0) && (($urandom_range(0, 1) == 1) || m_out[i] > 30);
      end
      step(-1, "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule